// File: doc/BRIEF.md
# Instruction-Addressed Operand Register File

This block holds thirty-two general-purpose registers, each 32 bits wide. It takes every register address straight from fixed fields of the current instruction word, so the decode logic does not have to route addresses. Two source fields select the operands that go into the A and B output registers. The destination field is picked according to the instruction class, or forced to the top register when a jump-and-link result has to be stored.

Register 0 is not stored. A zero detector on each source address replaces the array value with zero whenever address 0 is selected, and any write aimed at register 0 is dropped. In any one cycle the storage either serves both reads or takes one write. When a read and a write are requested together, the write is performed, the operand registers keep their old values, and a conflict flag is raised for that cycle.

Top module: `regfile_env`

## Requirements
- R1: When `rd_strobe` is high and `wr_en` is low, the next rising edge loads `opnd_a` from the register addressed by `instr[25:21]` and `opnd_b` from the register addressed by `instr[20:16]`.
- R2: With `wr_en` high, `itype_sel` low and `link_sel` low, the rising edge writes `wr_data` into the register addressed by `instr[15:11]`.
- R3: With `wr_en` high, `itype_sel` high and `link_sel` low, the rising edge writes `wr_data` into the register addressed by `instr[20:16]`.
- R4: With `wr_en` high and `link_sel` high, the write goes to register 31, whatever the value of `itype_sel` and of the instruction fields.
- R5: A read of source address 0 loads zero into the matching operand register.
- R6: A write addressed to register 0 is discarded, so register 0 still reads as zero afterwards.
- R7: While `wr_en` is low, no register changes, whatever `wr_data` and the instruction fields hold.
- R8: While `rd_strobe` is low, `opnd_a` and `opnd_b` hold their values.
- R9: When `rd_strobe` and `wr_en` are both high, the write is performed, both operand registers keep their values, and `rd_conflict` is high during that cycle.
- R10: A synchronous reset clears `opnd_a` and `opnd_b` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word that supplies the register addresses |
| itype_sel | input | 1 | Selects the immediate-format destination field |
| link_sel | input | 1 | Forces the destination to register 31 |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Value to write |
| rd_strobe | input | 1 | Operand read request |
| opnd_a | output | 32 | First operand register |
| opnd_b | output | 32 | Second operand register |
| rd_conflict | output | 1 | High when a read and a write are requested in the same cycle |

## Verification
A wrong destination choice or a missing write cannot be seen until a later read of that register. The bench therefore fills every register with a value that depends on its index, and then reads all of them through both source paths. A corrupted entry or a swapped field then shows up in `opnd_a` or `opnd_b` one edge after the read strobe. Conflict, hold and ignored-write cases are checked right at the edge where the operand registers would wrongly change, and again by a later read of the register that was targeted.

// File: rtl/regfile_env.sv
module regfile_env #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int IW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     instr,
  input  logic              itype_sel,
  input  logic              link_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              rd_conflict
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int SRC1_LSB = IW - 6 - ADDR_W;
  localparam int SRC2_LSB = SRC1_LSB - ADDR_W;
  localparam int DST_LSB  = SRC2_LSB - ADDR_W;
  localparam logic [ADDR_W-1:0] LINK_REG = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] bank [DEPTH];
  logic [ADDR_W-1:0] src1, src2, dst;
  logic              src1_zero, src2_zero, do_read;
  logic              unused_bits;

  assign src1 = instr[SRC1_LSB +: ADDR_W];
  assign src2 = instr[SRC2_LSB +: ADDR_W];
  assign dst  = link_sel  ? LINK_REG :
                itype_sel ? src2 : instr[DST_LSB +: ADDR_W];

  assign src1_zero   = (src1 == '0);
  assign src2_zero   = (src2 == '0);
  assign do_read     = rd_strobe && !wr_en;
  assign rd_conflict = rd_strobe && wr_en;
  assign unused_bits = ^{instr[IW-1:SRC1_LSB+ADDR_W], instr[DST_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (wr_en && dst != '0)
      bank[dst] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_a <= '0;
      opnd_b <= '0;
    end else if (do_read) begin
      opnd_a <= src1_zero ? '0 : bank[src1];
      opnd_b <= src2_zero ? '0 : bank[src2];
    end
  end
endmodule

// File: rtl/regfile_env_chk.sv
module regfile_env_chk #(
  parameter int DATA_W = 32,
  parameter int IW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [IW-1:0]     instr,
  input logic              wr_en,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              rd_conflict
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (opnd_a == '0 && opnd_b == '0)); // R10
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> ($stable(opnd_a) && $stable(opnd_b))); // R8
  AST_ZERO_SRC_A: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !wr_en && instr[25:21] == 5'd0) |=> opnd_a == '0); // R5
  AST_ZERO_SRC_B: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !wr_en && instr[20:16] == 5'd0) |=> opnd_b == '0); // R5
  AST_CONFLICT_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_conflict |=> ($stable(opnd_a) && $stable(opnd_b))); // R9
  AST_CONFLICT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rd_conflict |-> (wr_en && rd_strobe)); // R9
endmodule

bind regfile_env regfile_env_chk #(.DATA_W(DATA_W), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .instr(instr), .wr_en(wr_en), .rd_strobe(rd_strobe),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .rd_conflict(rd_conflict)
);

// File: tb/regfile_env_test.sv
`timescale 1ns/1ps
module regfile_env_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        itype_sel = 1'b0, link_sel = 1'b0, wr_en = 1'b0, rd_strobe = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] opnd_a, opnd_b;
  logic        rd_conflict;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [32];

  regfile_env uut (
    .clk(clk), .rst(rst), .instr(instr), .itype_sel(itype_sel), .link_sel(link_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .rd_conflict(rd_conflict)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    return (32'(i) * 32'h01030507) ^ (32'(salt) * 32'h9E3779B9) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] expv(input int r);
    return (r == 0) ? 32'h0 : model[r];
  endfunction

  task automatic write_op(input logic it, input logic lk, input int rs2, input int rd, input logic [31:0] d);
    instr = {6'h23, 5'd7, 5'(rs2), 5'(rd), 11'h2A5};
    itype_sel = it; link_sel = lk; wr_en = 1'b1; wr_data = d; rd_strobe = 1'b0;
    tick();
    wr_en = 1'b0; itype_sel = 1'b0; link_sel = 1'b0;
  endtask

  task automatic read_op(input int r1, input int r2, input string req);
    instr = {6'h00, 5'(r1), 5'(r2), 5'd9, 11'h0};
    rd_strobe = 1'b1;
    tick();
    rd_strobe = 1'b0;
    check(req, opnd_a, expv(r1));
    check(req, opnd_b, expv(r2));
  endtask

  initial begin
    logic [31:0] ha, hb;
    tick(); tick();
    check("R10 reset A", opnd_a, 32'h0);
    check("R10 reset B", opnd_b, 32'h0);
    rst = 1'b0;

    // R2: destination from bits 15:11, bits 20:16 hold a different index
    for (int i = 1; i < 32; i++) begin
      write_op(1'b0, 1'b0, 31 - i, i, pat(i, 1));
      model[i] = pat(i, 1);
    end
    for (int i = 0; i < 32; i++) read_op(i, (i * 7 + 3) % 32, "R1 R2 R5 sweep");

    // R3: destination from bits 20:16, bits 15:11 hold a different index
    for (int i = 1; i < 32; i++) begin
      write_op(1'b1, 1'b0, i, (i + 5) % 32, pat(i, 2));
      model[i] = pat(i, 2);
    end
    for (int i = 0; i < 32; i++) read_op((i * 11) % 32, i, "R1 R3 sweep");

    // R4: link forces register 31 in both formats
    write_op(1'b0, 1'b1, 4, 6, 32'hCAFE0031);
    model[31] = 32'hCAFE0031;
    read_op(31, 6, "R4 link R-format");
    write_op(1'b1, 1'b1, 4, 6, 32'hBEEF1F1F);
    model[31] = 32'hBEEF1F1F;
    read_op(4, 31, "R4 link I-format");

    // R6: writes aimed at register 0 are dropped
    write_op(1'b0, 1'b0, 3, 0, 32'hFFFFFFFF);
    write_op(1'b1, 1'b0, 0, 3, 32'h12345678);
    read_op(0, 0, "R6 r0 still zero");
    read_op(3, 0, "R6 r3 untouched");

    // R7: no write without wr_en
    instr = {6'h0, 5'd1, 5'd2, 5'd2, 11'h0};
    itype_sel = 1'b1; wr_data = 32'hDEADDEAD; wr_en = 1'b0;
    tick(); tick();
    itype_sel = 1'b0;
    read_op(2, 2, "R7 no write");

    // R8: hold while strobe low
    read_op(5, 9, "R1 setup");
    ha = opnd_a; hb = opnd_b;
    instr = {6'h0, 5'd12, 5'd13, 5'd0, 11'h0};
    tick(); tick();
    check("R8 hold A", opnd_a, ha);
    check("R8 hold B", opnd_b, hb);

    // R9: read and write together
    ha = opnd_a; hb = opnd_b;
    instr = {6'h0, 5'd20, 5'd21, 5'd22, 11'h0};
    wr_en = 1'b1; rd_strobe = 1'b1; wr_data = 32'h0BADF00D;
    #1;
    check("R9 flag high", 32'(rd_conflict), 32'h1);
    tick();
    wr_en = 1'b0; rd_strobe = 1'b0;
    model[22] = 32'h0BADF00D;
    check("R9 A kept", opnd_a, ha);
    check("R9 B kept", opnd_b, hb);
    #1;
    check("R9 flag low", 32'(rd_conflict), 32'h0);
    read_op(22, 20, "R9 write done");

    // R10: reset in mid-run
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R10 mid reset A", opnd_a, 32'h0);
    check("R10 mid reset B", opnd_b, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule